// File: doc/BRIEF.md
# UART Status and Interrupt Identification Unit

This block is the status side of a 16550-style serial port, with no shift engines inside it. Event strobes come in from the receiver and the transmitter. Four low-active modem-control pins arrive from outside the chip. The block keeps three software-visible registers:

- a line status word;
- a modem status word;
- an interrupt identification word, which names the highest-priority pending and enabled source.

Some bits in these registers are sticky: a read of the register that holds them clears them. The read-clear is free of races. A hardware event that lands in the same clock as the clearing read is not lost. That read returns the previous contents, and the new event remains set for the next read.

A read is a one-cycle `rd_en` strobe together with a register select on `rd_sel`. The value appears on `rd_data` one clock later and holds until the next read. `irq` is high whenever the identification word reports a pending source.

Top module: `uart_status_regs`

## Requirements
- R1: Line status (select 0) carries bit0 receive-data-ready (the level of `rx_ready`), bit1 overrun, bit2 parity error, bit3 framing error, bit4 break, bit5 holding-register idle, and zeros in bits 7:6. Bits 4:1 are set by `rx_err_ev` bits 0..3 respectively and stay set until a line status read clears them.
- R2: A line status error strobe in the same cycle as a line status read is not erased: the read returns the old value and the next read shows the new bit.
- R3: Modem status (select 2) carries bit0 delta-CTS, bit1 delta-DSR, bit2 trailing-edge RI, bit3 delta-DCD, and the active-high levels bit4 CTS, bit5 DSR, bit6 RI, bit7 DCD. `modem_n` bits 0..3 are CTS, DSR, RI and DCD, active low, and each passes through two synchronizing flops. Any change of a synchronized CTS, DSR or DCD sets its delta bit, and a modem status read clears all four delta bits.
- R4: The trailing-edge RI bit is set only when RI goes from active to inactive; RI becoming active sets no delta bit.
- R5: A modem delta event in the same cycle as a modem status read survives that read and is returned by the next one.
- R6: Interrupt identification (select 1) returns 0x06 for line status errors, 0x04 for receive data ready, 0x02 for holding-register empty, 0x00 for a modem delta, and 0x01 when nothing is pending, with priority in that order. `int_en` bit0 enables receive data, bit1 holding-register empty, bit2 line status and bit3 modem.
- R7: A `thre_ev` strobe marks holding-register empty pending. An identification read clears that pending flag only when 0x02 is the code it returns.
- R8: A `thre_ev` strobe in the same cycle as an identification read that reports 0x02 keeps the flag pending.
- R9: `thr_write` clears both the holding-register-empty pending flag and the idle bit; `thre_ev` sets both again, and a strobe wins over a same-cycle write.
- R10: A source whose `int_en` bit is low is not reported, and `irq` is high exactly when the identification word would return a code with bit0 low.
- R11: After reset `rd_data` is 0, line status reads 0x20, identification reads 0x01 and modem status reads 0x00 with the pins inactive. `rd_data` changes only the cycle after `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_ready | input | 1 | Receiver holds unread data (level) |
| rx_err_ev | input | 4 | Error strobes: 0 overrun, 1 parity, 2 framing, 3 break |
| thre_ev | input | 1 | Transmit holding register became empty (strobe) |
| thr_write | input | 1 | Software wrote the transmit holding register (strobe) |
| modem_n | input | 4 | Asynchronous low-active pins: 0 CTS, 1 DSR, 2 RI, 3 DCD |
| int_en | input | 4 | Interrupt enables: 0 rx data, 1 tx empty, 2 line status, 3 modem |
| rd_en | input | 1 | Register read strobe |
| rd_sel | input | 2 | 0 line status, 1 identification, 2 modem status, 3 reads zero |
| rd_data | output | 8 | Read data, registered, valid the cycle after rd_en |
| irq | output | 1 | Interrupt request |

## Verification
The bench drives an error strobe, a modem pin change and a transmitter-empty strobe so that each lands in the exact cycle of the read that clears it. A design that cleared and then set in the wrong order would drop the event, and the second read would come back without it. It also reads the identification word while a higher-priority source masks the transmitter-empty source. A design that cleared that flag on every identification read would then report nothing once the higher source went away. Raising RI checks that only its trailing edge marks a delta. Masking all enables with errors pending checks that neither the code nor `irq` leaks the masked source.

// File: rtl/uart_stat_pkg.sv
package uart_stat_pkg;
  localparam int REG_W = 8;
  localparam int ERR_W = 4;
  localparam int PIN_W = 4;

  typedef enum logic [1:0] {
    SEL_LSR  = 2'd0,
    SEL_IIR  = 2'd1,
    SEL_MSR  = 2'd2,
    SEL_RSVD = 2'd3
  } reg_sel_e;

  localparam logic [3:0] ID_NONE = 4'b0001;
  localparam logic [3:0] ID_RLS  = 4'b0110;
  localparam logic [3:0] ID_RDA  = 4'b0100;
  localparam logic [3:0] ID_THRE = 4'b0010;
  localparam logic [3:0] ID_MS   = 4'b0000;
endpackage

// File: rtl/uart_sticky_bits.sv
module uart_sticky_bits #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] q_o
);
  // Set has priority over a same-cycle clearing read.
  always_ff @(posedge clk) begin
    if (rst) q_o <= '0;
    else     q_o <= (q_o & ~{W{clr_i}}) | set_i;
  end

  // R2 / R5: an event in the read cycle is still present afterwards
  p_set_survives_r2: assert property (@(posedge clk) disable iff (rst)
    (|set_i) |=> ((q_o & $past(set_i)) == $past(set_i)));

  // R1 / R3: a clearing read leaves only same-cycle events
  p_clear_on_read_r1: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> ((q_o & ~$past(set_i)) == '0));
endmodule

// File: rtl/uart_line_status.sv
module uart_line_status
  import uart_stat_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [ERR_W-1:0] err_ev_i,
  input  logic             rx_ready_i,
  input  logic             thre_ev_i,
  input  logic             thr_wr_i,
  input  logic             lsr_clr_i,
  output logic [REG_W-1:0] lsr_o,
  output logic             err_any_o
);
  logic [ERR_W-1:0] err_q;
  logic             thr_idle_q;

  uart_sticky_bits #(.W(ERR_W)) u_err (
    .clk  (clk),
    .rst  (rst),
    .set_i(err_ev_i),
    .clr_i(lsr_clr_i),
    .q_o  (err_q)
  );

  always_ff @(posedge clk) begin
    if (rst)            thr_idle_q <= 1'b1;
    else if (thre_ev_i) thr_idle_q <= 1'b1;
    else if (thr_wr_i)  thr_idle_q <= 1'b0;
  end

  assign lsr_o     = {2'b00, thr_idle_q, err_q, rx_ready_i};
  assign err_any_o = |err_q;

  // R9: the empty strobe wins over a same-cycle write
  p_idle_set_r9: assert property (@(posedge clk) disable iff (rst)
    thre_ev_i |=> thr_idle_q);
endmodule

// File: rtl/uart_modem_track.sv
module uart_modem_track
  import uart_stat_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PIN_W-1:0] pins_n_i,
  input  logic             msr_clr_i,
  output logic [REG_W-1:0] msr_o,
  output logic             delta_any_o
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [PIN_W-1:0] sync_q [SYNC_STAGES];
  logic [PIN_W-1:0] prev_q;
  logic [PIN_W-1:0] settled_n;
  logic [PIN_W-1:0] level;
  logic [PIN_W-1:0] chg;
  logic [PIN_W-1:0] delta_ev;
  logic [PIN_W-1:0] delta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SYNC_STAGES; s++) sync_q[s] <= '1;
      prev_q <= '1;
    end else begin
      sync_q[0] <= pins_n_i;
      for (int s = 1; s < SYNC_STAGES; s++) sync_q[s] <= sync_q[s-1];
      prev_q <= sync_q[LAST];
    end
  end

  assign settled_n = sync_q[LAST];
  assign level     = ~settled_n;
  assign chg       = settled_n ^ prev_q;
  // index 0 CTS, 1 DSR, 2 RI (trailing edge only), 3 DCD
  assign delta_ev  = {chg[3], ~prev_q[2] & settled_n[2], chg[1], chg[0]};

  uart_sticky_bits #(.W(PIN_W)) u_delta (
    .clk  (clk),
    .rst  (rst),
    .set_i(delta_ev),
    .clr_i(msr_clr_i),
    .q_o  (delta_q)
  );

  assign msr_o       = {level, delta_q};
  assign delta_any_o = |delta_q;

  // R4: trailing-edge RI only appears after RI went active to inactive
  p_teri_trailing_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(delta_q[2]) |-> $past(~prev_q[2] & settled_n[2]));
endmodule

// File: rtl/uart_int_ident.sv
module uart_int_ident
  import uart_stat_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       ier_i,
  input  logic             err_any_i,
  input  logic             rx_ready_i,
  input  logic             ms_any_i,
  input  logic             thre_ev_i,
  input  logic             thr_wr_i,
  input  logic             iir_rd_i,
  output logic [REG_W-1:0] iir_o,
  output logic             irq_o
);
  logic       thre_pend_q;
  logic [3:0] id;

  always_comb begin
    if (ier_i[2] && err_any_i)        id = ID_RLS;
    else if (ier_i[0] && rx_ready_i)  id = ID_RDA;
    else if (ier_i[1] && thre_pend_q) id = ID_THRE;
    else if (ier_i[3] && ms_any_i)    id = ID_MS;
    else                              id = ID_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst)                                       thre_pend_q <= 1'b0;
    else if (thre_ev_i)                            thre_pend_q <= 1'b1;
    else if (thr_wr_i || (iir_rd_i && id == ID_THRE)) thre_pend_q <= 1'b0;
  end

  assign iir_o = {4'b0000, id};
  assign irq_o = (id != ID_NONE);

  // R8: strobe during the identification read keeps the flag
  p_thre_survives_r8: assert property (@(posedge clk) disable iff (rst)
    thre_ev_i |=> thre_pend_q);

  // R7: reporting read without a new strobe clears the flag
  p_thre_cleared_r7: assert property (@(posedge clk) disable iff (rst)
    (iir_rd_i && iir_o[3:0] == ID_THRE && !thre_ev_i) |=> !thre_pend_q);

  // R6: enabled line errors always take the top code
  p_rls_first_r6: assert property (@(posedge clk) disable iff (rst)
    (ier_i[2] && err_any_i) |-> (iir_o[3:0] == ID_RLS));

  // R10: irq agrees with the pending bit of the code
  p_irq_code_r10: assert property (@(posedge clk) disable iff (rst)
    irq_o == !iir_o[0]);
endmodule

// File: rtl/uart_status_regs.sv
module uart_status_regs
  import uart_stat_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_ready,
  input  logic [ERR_W-1:0] rx_err_ev,
  input  logic             thre_ev,
  input  logic             thr_write,
  input  logic [PIN_W-1:0] modem_n,
  input  logic [3:0]       int_en,
  input  logic             rd_en,
  input  logic [1:0]       rd_sel,
  output logic [REG_W-1:0] rd_data,
  output logic             irq
);
  logic [REG_W-1:0] lsr, msr, iir;
  logic             err_any, ms_any;
  logic             lsr_rd, msr_rd, iir_rd;
  reg_sel_e         sel;

  assign sel    = reg_sel_e'(rd_sel);
  assign lsr_rd = rd_en && sel == SEL_LSR;
  assign msr_rd = rd_en && sel == SEL_MSR;
  assign iir_rd = rd_en && sel == SEL_IIR;

  uart_line_status u_line (
    .clk       (clk),
    .rst       (rst),
    .err_ev_i  (rx_err_ev),
    .rx_ready_i(rx_ready),
    .thre_ev_i (thre_ev),
    .thr_wr_i  (thr_write),
    .lsr_clr_i (lsr_rd),
    .lsr_o     (lsr),
    .err_any_o (err_any)
  );

  uart_modem_track #(.SYNC_STAGES(SYNC_STAGES)) u_modem (
    .clk        (clk),
    .rst        (rst),
    .pins_n_i   (modem_n),
    .msr_clr_i  (msr_rd),
    .msr_o      (msr),
    .delta_any_o(ms_any)
  );

  uart_int_ident u_ident (
    .clk       (clk),
    .rst       (rst),
    .ier_i     (int_en),
    .err_any_i (err_any),
    .rx_ready_i(rx_ready),
    .ms_any_i  (ms_any),
    .thre_ev_i (thre_ev),
    .thr_wr_i  (thr_write),
    .iir_rd_i  (iir_rd),
    .iir_o     (iir),
    .irq_o     (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      case (sel)
        SEL_LSR: rd_data <= lsr;
        SEL_IIR: rd_data <= iir;
        SEL_MSR: rd_data <= msr;
        default: rd_data <= '0;
      endcase
    end
  end

  // R11: read data only moves after a read strobe
  p_rd_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
endmodule

// File: tb/uart_status_regs_tb.sv
module uart_status_regs_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic       rx_ready;
  logic [3:0] rx_err_ev;
  logic       thre_ev;
  logic       thr_write;
  logic [3:0] modem_n;
  logic [3:0] int_en;
  logic       rd_en;
  logic [1:0] rd_sel;
  logic [7:0] rd_data;
  logic       irq;

  always #5 clk = ~clk;

  uart_status_regs u_dut (
    .clk      (clk),
    .rst      (rst),
    .rx_ready (rx_ready),
    .rx_err_ev(rx_err_ev),
    .thre_ev  (thre_ev),
    .thr_write(thr_write),
    .modem_n  (modem_n),
    .int_en   (int_en),
    .rd_en    (rd_en),
    .rd_sel   (rd_sel),
    .rd_data  (rd_data),
    .irq      (irq)
  );

  localparam logic [1:0] LSR = 2'd0, IIR = 2'd1, MSR = 2'd2;
  localparam logic [3:0] OVR = 4'b0001, PAR = 4'b0010, FRM = 4'b0100;

  typedef struct {
    logic [7:0] val;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  exp_t mon_e;
  int   checks = 0;
  int   errors = 0;
  bit   done   = 1'b0;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // driver: one read strobe, optional same-cycle events, expected value queued
  task automatic do_read(input logic [1:0] sel, input logic [3:0] lev, input logic tev,
                         input logic [7:0] exp, input string tag);
    exp_t e;
    @(negedge clk);
    rd_en = 1'b1; rd_sel = sel; rx_err_ev = lev; thre_ev = tev;
    e.val = exp; e.tag = tag;
    exp_q.push_back(e);
    @(posedge clk);
    #1 rd_en = 1'b0; rx_err_ev = '0; thre_ev = 1'b0;
  endtask

  task automatic pulse(input logic [3:0] lev, input logic tev, input logic wr);
    @(negedge clk);
    rx_err_ev = lev; thre_ev = tev; thr_write = wr;
    @(posedge clk);
    #1 rx_err_ev = '0; thre_ev = 1'b0; thr_write = 1'b0;
  endtask

  task automatic settle();
    repeat (6) @(posedge clk);
  endtask

  // monitor: pops the scoreboard when a read result lands
  always begin
    @(posedge clk);
    if (rd_en) begin
      #2;
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard actual=%02h expected=none", rd_data);
      end else begin
        mon_e = exp_q.pop_front();
        check(mon_e.tag, rd_data, mon_e.val);
      end
    end
  end

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      report();
      $finish;
    end
  end

  initial begin
    rst = 1'b1; rx_ready = 1'b0; rx_err_ev = '0; thre_ev = 1'b0; thr_write = 1'b0;
    modem_n = 4'hF; int_en = 4'h0; rd_en = 1'b0; rd_sel = 2'd0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R11 reset state
    check("R11 reset rd_data", rd_data, 8'h00);
    do_read(LSR, 0, 0, 8'h20, "R11 reset line status");
    do_read(IIR, 0, 0, 8'h01, "R11 reset ident");
    do_read(MSR, 0, 0, 8'h00, "R11 reset modem");

    // R1 sticky error, cleared by read
    pulse(PAR, 0, 0);
    do_read(LSR, 0, 0, 8'h24, "R1 parity set");
    do_read(LSR, 0, 0, 8'h20, "R1 parity cleared");
    pulse(PAR, 0, 0);
    @(negedge clk);
    check("R11 hold without read", rd_data, 8'h20);
    do_read(LSR, 0, 0, 8'h24, "R1 parity again");

    // R2 race on line status
    pulse(OVR, 0, 0);
    do_read(LSR, FRM, 0, 8'h22, "R2 old value");
    do_read(LSR, 0, 0, 8'h28, "R2 framing survived");
    do_read(LSR, 0, 0, 8'h20, "R2 cleared");

    // R3 modem deltas
    @(negedge clk) modem_n[0] = 1'b0;
    settle();
    do_read(MSR, 0, 0, 8'h11, "R3 cts delta");
    do_read(MSR, 0, 0, 8'h10, "R3 cts cleared");
    @(negedge clk) begin modem_n[1] = 1'b0; modem_n[3] = 1'b0; end
    settle();
    do_read(MSR, 0, 0, 8'hBA, "R3 dsr dcd deltas");
    do_read(MSR, 0, 0, 8'hB0, "R3 deltas cleared");

    // R4 trailing-edge RI
    @(negedge clk) modem_n[2] = 1'b0;
    settle();
    do_read(MSR, 0, 0, 8'hF0, "R4 RI rising no delta");
    @(negedge clk) modem_n[2] = 1'b1;
    settle();
    do_read(MSR, 0, 0, 8'hB4, "R4 RI trailing edge");
    do_read(MSR, 0, 0, 8'hB0, "R4 cleared");

    // R5 modem delta lands in the read cycle
    @(negedge clk) modem_n[3] = 1'b1;
    @(posedge clk);
    @(posedge clk);
    do_read(MSR, 0, 0, 8'h30, "R5 old deltas");
    do_read(MSR, 0, 0, 8'h38, "R5 dcd delta survived");
    do_read(MSR, 0, 0, 8'h30, "R5 cleared");

    // R6 / R7 priority and conditional clear
    int_en = 4'hF;
    do_read(IIR, 0, 0, 8'h01, "R6 nothing pending");
    pulse(0, 1, 0);
    do_read(IIR, 0, 0, 8'h02, "R7 thre reported");
    do_read(IIR, 0, 0, 8'h01, "R7 thre cleared by read");
    pulse(0, 1, 0);
    @(negedge clk) rx_ready = 1'b1;
    do_read(IIR, 0, 0, 8'h04, "R6 rx data over thre");
    do_read(IIR, 0, 0, 8'h04, "R7 masked thre kept");
    @(negedge clk);
    check("R10 irq high", {7'b0, irq}, 8'h01);
    pulse(PAR, 0, 0);
    do_read(IIR, 0, 0, 8'h06, "R6 line status top");
    do_read(LSR, 0, 0, 8'h25, "R1 ready plus parity");
    do_read(IIR, 0, 0, 8'h04, "R6 back to rx data");
    @(negedge clk) rx_ready = 1'b0;
    do_read(IIR, 0, 0, 8'h02, "R7 thre still pending");
    @(negedge clk) modem_n[0] = 1'b1;
    settle();
    do_read(IIR, 0, 0, 8'h00, "R6 modem lowest");
    do_read(MSR, 0, 0, 8'h21, "R3 cts release delta");
    do_read(IIR, 0, 0, 8'h01, "R6 all serviced");

    // R8 thre strobe during reporting read
    pulse(0, 1, 0);
    do_read(IIR, 0, 1, 8'h02, "R8 read returns thre");
    do_read(IIR, 0, 0, 8'h02, "R8 thre survived");
    do_read(IIR, 0, 0, 8'h01, "R8 cleared");

    // R9 holding-register write
    pulse(0, 1, 0);
    pulse(0, 0, 1);
    do_read(IIR, 0, 0, 8'h01, "R9 write clears pending");
    do_read(LSR, 0, 0, 8'h00, "R9 write clears idle");
    pulse(0, 1, 1);
    do_read(LSR, 0, 0, 8'h20, "R9 strobe wins over write");

    // R10 enables mask sources
    int_en = 4'h0;
    pulse(PAR, 0, 0);
    do_read(IIR, 0, 0, 8'h01, "R10 masked ident");
    @(negedge clk);
    check("R10 irq low when masked", {7'b0, irq}, 8'h00);
    do_read(LSR, 0, 0, 8'h24, "R1 masked error still latched");
    @(negedge clk) int_en = 4'hF;
    @(negedge clk);
    check("R10 irq on enable", {7'b0, irq}, 8'h01);
    do_read(IIR, 0, 0, 8'h02, "R10 thre after enable");

    repeat (4) @(posedge clk);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard actual=%0d expected=0 pending", exp_q.size());
    end
    done = 1'b1;
    report();
    $finish;
  end
endmodule